// File: doc/BRIEF.md
# Multi-Processor Interrupt Hub

This block collects interrupt requests from devices into one shared raw request word and gives every processor its own view of that word through a private mask. A processor's pending word is the raw word ANDed with its mask. Each processor receives one device-interrupt line, which is high when its pending word has any bit set. The block also holds two small flag sets with one bit per processor. One set is for inter-processor interrupts and the other is for interval-timer interrupts. Each flag drives its own output line.

Device logic posts and clears raw bits by index through two strobe ports. The timer pulse sets the timer flag of every processor. Software uses a small register port with an address, a write enable, 64-bit write data and combinational read data. Through this port it programs the masks, reads the pending words and the raw word, raises and drops inter-processor flags by processor bitmap, and drops timer flags by bitmap.

Register map with the default four processors, where the address is 4 bits wide. Address k (0..3) is the mask of processor k. Address 4+k is the pending word of processor k and is read-only. Addresses 8..11 are unused. Address 12 reads the inter-processor flags, and a write to it sets the flags given by the bitmap. Address 13 reads the inter-processor flags, and a write to it clears the flags given by the bitmap. Address 14 reads the timer flags, and a write to it clears the timer flags given by the bitmap. Address 15 reads the raw word and ignores writes. Flag reads are zero-extended to 64 bits.

Top module: `irq_hub`

## Requirements
- R1: After reset, all masks, the raw word, both flag sets and all output lines read as zero.
- R2: A write to mask address k stores the full 64-bit write data as processor k's mask. Reading that address returns it from the next cycle onward, and other masks keep their values.
- R3: Reading pending address 4+k returns raw AND mask k. The result reflects a mask write or a raw change in the first cycle after the clock edge that stored it.
- R4: A post strobe with index i sets raw bit i, and a clear strobe with index i clears raw bit i. When both strobes name the same bit in one cycle, the bit ends up set.
- R5: dev_irq[k] equals the OR of processor k's pending word as it was one cycle earlier.
- R6: A write to address 12 sets the inter-processor flags named by the low bits of the data, and a write to address 13 clears them. ipi_irq[k] equals flag k. Data bits at or above the processor count have no effect.
- R7: A timer pulse sets the timer flag of every processor. A write to address 14 clears the timer flags named by the bitmap. When a pulse and a clear arrive in the same cycle, the flags end up set. tmr_irq[k] equals timer flag k.
- R8: Address 12 and address 13 read the inter-processor flags, address 14 reads the timer flags, and address 15 reads the raw word. The flag reads carry zeros above the processor count.
- R9: Writes to the pending addresses, to addresses 8..11 and to address 15 change no mask, no raw bit and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| post_vld | input | 1 | Raw bit post strobe |
| post_idx | input | 6 | Index of raw bit to post |
| clr_vld | input | 1 | Raw bit clear strobe |
| clr_idx | input | 6 | Index of raw bit to clear |
| tmr_tick | input | 1 | Timer pulse, sets all timer flags |
| dev_irq | output | 4 | Per-processor device interrupt line |
| ipi_irq | output | 4 | Per-processor inter-processor interrupt line |
| tmr_irq | output | 4 | Per-processor timer interrupt line |

## Verification
The bench walks a sequence of posts and clears over raw bits 0, 1, 5 and 63, including a cycle where a post and a clear name the same bit. A design where the clear wins would lose that bit. The bench reads the pending word right after a mask write and watches dev_irq for one extra cycle, so an unregistered line or a stale pending read shows up as an off-by-one mismatch. Bitmaps with their upper bits set, timer pulses that coincide with clears, and writes to read-only or unused addresses target decode slips that would corrupt flags or masks.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    typedef enum logic [1:0] {
        GRP_MASK = 2'd0,
        GRP_PEND = 2'd1,
        GRP_NONE = 2'd2,
        GRP_CTRL = 2'd3
    } grp_e;

    localparam logic [1:0] CTRL_IPI_SET = 2'd0;
    localparam logic [1:0] CTRL_IPI_CLR = 2'd1;
    localparam logic [1:0] CTRL_TMR_CLR = 2'd2;
    localparam logic [1:0] CTRL_RAW     = 2'd3;
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
    parameter int RAW_W = 64,
    localparam int IW = $clog2(RAW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_vld,
    input  logic [IW-1:0]    post_idx,
    input  logic             clr_vld,
    input  logic [IW-1:0]    clr_idx,
    output logic [RAW_W-1:0] raw
);
    typedef struct packed {
        logic [RAW_W-1:0] raw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [RAW_W-1:0] set_m, clr_m;
        set_m = post_vld ? (RAW_W'(1) << post_idx) : '0;
        clr_m = clr_vld  ? (RAW_W'(1) << clr_idx)  : '0;
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~clr_m) | set_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = st_q.raw;

    // R4
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld |=> raw[$past(post_idx)]);

    // R4
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !(post_vld && post_idx == clr_idx)) |=> !raw[$past(clr_idx)]);
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
    parameter int RAW_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [RAW_W-1:0] wdata,
    input  logic [RAW_W-1:0] raw,
    output logic [RAW_W-1:0] mask,
    output logic [RAW_W-1:0] pend,
    output logic             dev_irq
);
    typedef struct packed {
        logic [RAW_W-1:0] mask;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (mask_we) st_d.mask = wdata;
        st_d.irq  = |(raw & st_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask    = st_q.mask;
    assign pend    = raw & st_q.mask;
    assign dev_irq = st_q.irq;

    // R2
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask == $past(wdata));

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> dev_irq == $past(|pend));
endmodule

// File: rtl/irq_flag_set.sv
module irq_flag_set #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_vld,
    input  logic [N-1:0] set_map,
    input  logic         clr_vld,
    input  logic [N-1:0] clr_map,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [N-1:0] s, c;
        s = set_vld ? set_map : '0;
        c = clr_vld ? clr_map : '0;
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~c) | s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R6 R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> (flags & $past(set_map)) == $past(set_map));

    // R6 R7
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !set_vld) |=> (flags & $past(clr_map)) == '0);
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
    parameter int NCPU  = 4,
    parameter int RAW_W = 64,
    localparam int IW     = $clog2(RAW_W),
    localparam int SEL_W  = (NCPU > 4) ? $clog2(NCPU) : 2,
    localparam int ADDR_W = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [RAW_W-1:0]  reg_wdata,
    output logic [RAW_W-1:0]  reg_rdata,
    input  logic              post_vld,
    input  logic [IW-1:0]     post_idx,
    input  logic              clr_vld,
    input  logic [IW-1:0]     clr_idx,
    input  logic              tmr_tick,
    output logic [NCPU-1:0]   dev_irq,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq
);
    import irq_hub_pkg::*;

    grp_e             grp;
    logic [SEL_W-1:0] sel;
    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] mask_arr [NCPU];
    logic [RAW_W-1:0] pend_arr [NCPU];
    logic [NCPU-1:0]  ipi_flags, tmr_flags;
    logic             ctl_we;

    assign grp    = grp_e'(reg_addr[ADDR_W-1 -: 2]);
    assign sel    = reg_addr[SEL_W-1:0];
    assign ctl_we = reg_we && (grp == GRP_CTRL);

    irq_raw_reg #(.RAW_W(RAW_W)) u_raw (
        .clk(clk), .rst_n(rst_n),
        .post_vld(post_vld), .post_idx(post_idx),
        .clr_vld(clr_vld), .clr_idx(clr_idx),
        .raw(raw)
    );

    for (genvar k = 0; k < NCPU; k++) begin : g_cpu
        logic we_k;
        assign we_k = reg_we && (grp == GRP_MASK) && (sel == SEL_W'(k));
        irq_cpu_slice #(.RAW_W(RAW_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .mask_we(we_k), .wdata(reg_wdata), .raw(raw),
            .mask(mask_arr[k]), .pend(pend_arr[k]), .dev_irq(dev_irq[k])
        );
    end

    irq_flag_set #(.N(NCPU)) u_ipi (
        .clk(clk), .rst_n(rst_n),
        .set_vld(ctl_we && sel[1:0] == CTRL_IPI_SET), .set_map(reg_wdata[NCPU-1:0]),
        .clr_vld(ctl_we && sel[1:0] == CTRL_IPI_CLR), .clr_map(reg_wdata[NCPU-1:0]),
        .flags(ipi_flags)
    );

    irq_flag_set #(.N(NCPU)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .set_vld(tmr_tick), .set_map({NCPU{1'b1}}),
        .clr_vld(ctl_we && sel[1:0] == CTRL_TMR_CLR), .clr_map(reg_wdata[NCPU-1:0]),
        .flags(tmr_flags)
    );

    assign ipi_irq = ipi_flags;
    assign tmr_irq = tmr_flags;

    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_MASK: for (int k = 0; k < NCPU; k++)
                          if (sel == SEL_W'(k)) reg_rdata = mask_arr[k];
            GRP_PEND: for (int k = 0; k < NCPU; k++)
                          if (sel == SEL_W'(k)) reg_rdata = pend_arr[k];
            GRP_CTRL: begin
                unique case (sel[1:0])
                    CTRL_IPI_SET, CTRL_IPI_CLR: reg_rdata = RAW_W'(ipi_flags);
                    CTRL_TMR_CLR:               reg_rdata = RAW_W'(tmr_flags);
                    default:                    reg_rdata = raw;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (raw == '0 && ipi_flags == '0 && tmr_flags == '0 && dev_irq == '0));

    // R9
    raw_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_vld && !clr_vld) |=> $stable(raw));
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        post_vld = 1'b0;
    logic [5:0]  post_idx = '0;
    logic        clr_vld = 1'b0;
    logic [5:0]  clr_idx = '0;
    logic        tmr_tick = 1'b0;
    logic [3:0]  dev_irq, ipi_irq, tmr_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_hub i_irq_hub (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .post_vld(post_vld), .post_idx(post_idx), .clr_vld(clr_vld), .clr_idx(clr_idx),
        .tmr_tick(tmr_tick),
        .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    typedef struct packed {
        logic        pv;
        logic [5:0]  pi;
        logic        cv;
        logic [5:0]  ci;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 6'd0,  1'b0, 6'd0,  64'h0000_0000_0000_0001},
        '{1'b1, 6'd63, 1'b0, 6'd0,  64'h8000_0000_0000_0001},
        '{1'b1, 6'd5,  1'b0, 6'd0,  64'h8000_0000_0000_0021},
        '{1'b1, 6'd5,  1'b1, 6'd5,  64'h8000_0000_0000_0021},
        '{1'b0, 6'd0,  1'b1, 6'd0,  64'h8000_0000_0000_0020},
        '{1'b1, 6'd1,  1'b1, 6'd63, 64'h0000_0000_0000_0022},
        '{1'b0, 6'd0,  1'b1, 6'd5,  64'h0000_0000_0000_0002},
        '{1'b0, 6'd0,  1'b1, 6'd1,  64'h0000_0000_0000_0000}
    };

    localparam logic [63:0] MASK0 = 64'h8000_0000_0000_00FF;
    localparam logic [63:0] MASK1 = 64'h0000_0000_0000_0022;
    localparam logic [63:0] MASK2 = 64'hFFFF_FFFF_0000_0000;
    localparam logic [63:0] MASK3 = 64'h0000_0000_FFFF_FFFF;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [63:0] mask_of(input int k);
        case (k)
            0: return MASK0;
            1: return MASK1;
            2: return MASK2;
            default: return MASK3;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 4; k++) begin rd(4'(k), d); chk("R1 mask", d, 0); end
        rd(4'd15, d); chk("R1 raw", d, 0);
        rd(4'd12, d); chk("R1 ipi", d, 0);
        rd(4'd14, d); chk("R1 tmr", d, 0);
        chk("R1 lines", {52'd0, dev_irq, ipi_irq, tmr_irq}, 0);
        rst_n = 1'b1;

        // R2 mask programming
        for (int k = 0; k < 4; k++) wr(4'(k), mask_of(k));
        for (int k = 0; k < 4; k++) begin rd(4'(k), d); chk("R2 mask", d, mask_of(k)); end

        // R4 R3 vector walk
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            post_vld = VECS[v].pv; post_idx = VECS[v].pi;
            clr_vld  = VECS[v].cv; clr_idx  = VECS[v].ci;
            @(negedge clk);
            post_vld = 1'b0; clr_vld = 1'b0;
            rd(4'd15, d); chk("R4 raw", d, VECS[v].exp);
            for (int k = 0; k < 4; k++) begin
                rd(4'(4 + k), d); chk("R3 pend", d, VECS[v].exp & mask_of(k));
            end
        end

        // R5 registered device line
        wr(4'd1, 64'h80);
        wr(4'd2, 64'h0);
        @(negedge clk); post_vld = 1'b1; post_idx = 6'd7;
        @(negedge clk); post_vld = 1'b0;
        rd(4'd5, d); chk("R3 pend same cycle", d, 64'h80);
        chk("R5 one cycle late", 64'(dev_irq[1]), 0);
        @(negedge clk);
        chk("R5 dev1 up", 64'(dev_irq[1]), 1);
        chk("R5 dev2 masked", 64'(dev_irq[2]), 0);
        chk("R5 dev0 up", 64'(dev_irq[0]), 1);
        wr(4'd1, 64'h0);
        rd(4'd5, d); chk("R3 pend after mask write", d, 0);
        chk("R5 still high", 64'(dev_irq[1]), 1);
        @(negedge clk);
        chk("R5 dev1 down", 64'(dev_irq[1]), 0);

        // R6 IPI flags
        wr(4'd12, 64'hFFFF_FFFF_FFFF_FFF5);
        rd(4'd12, d); chk("R6 R8 ipi set", d, 64'h5);
        chk("R6 ipi lines", 64'(ipi_irq), 64'h5);
        wr(4'd13, 64'hFFFF_FFFF_FFFF_FFF1);
        rd(4'd13, d); chk("R6 R8 ipi clr", d, 64'h4);

        // R7 timer flags
        @(negedge clk); tmr_tick = 1'b1;
        @(negedge clk); tmr_tick = 1'b0;
        rd(4'd14, d); chk("R7 tick", d, 64'hF);
        wr(4'd14, 64'h3);
        rd(4'd14, d); chk("R7 clr", d, 64'hC);
        chk("R7 lines", 64'(tmr_irq), 64'hC);
        @(negedge clk);
        tmr_tick = 1'b1; reg_addr = 4'd14; reg_we = 1'b1; reg_wdata = 64'hF;
        @(negedge clk);
        tmr_tick = 1'b0; reg_we = 1'b0;
        rd(4'd14, d); chk("R7 tick beats clr", d, 64'hF);

        // R9 ignored writes
        wr(4'd4, '1);
        wr(4'd9, '1);
        wr(4'd15, '1);
        rd(4'd0, d); chk("R9 mask0 kept", d, MASK0);
        rd(4'd1, d); chk("R9 mask1 kept", d, 0);
        rd(4'd15, d); chk("R9 raw kept", d, 64'h80);
        rd(4'd12, d); chk("R9 ipi kept", d, 64'h4);
        rd(4'd14, d); chk("R9 tmr kept", d, 64'hF);

        // R8 raw via read port after clear
        @(negedge clk); clr_vld = 1'b1; clr_idx = 6'd7;
        @(negedge clk); clr_vld = 1'b0;
        rd(4'd15, d); chk("R8 raw read", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule